// File: doc/BRIEF.md
# Timer Compare Output Unit with Force-Compare

An 8-bit up-counter is compared against two compare registers, A and B. Each channel owns one waveform output. When the counter takes the channel's compare value, the output changes by the channel's 2-bit output action, and the channel's interrupt flag is set. The counter runs in one of three waveform modes: free-running (normal), clear-on-compare where channel A's compare value is the top of the count, and a single PWM mode where the outputs follow a duty comparison. A clock-select field either stops the counter or advances it on every clock, or once every 8, 64, 256 or 1024 clocks of a free-running prescaler.

Software reaches the block through one synchronous register port: a write enable, an address, write data, and combinational read data for the same address. The control byte at address 1 also carries two force strobes. Writing a one to a strobe applies that channel's output action at once. This is not a real compare match: it sets no interrupt flag and never moves the counter. In PWM mode the strobes are ignored.

Register map (3-bit address): 0 = config (bits 5:4 action A, bits 3:2 action B, bits 1:0 low mode bits, other bits read 0); 1 = control; 2 = counter; 3 = compare A; 4 = compare B; 5 = flags (bit 0 A, bit 1 B).

Top module: `cmpo_timer`

## Requirements
- R1: After reset every register reads zero, both waveform outputs are 0 and both interrupt flags are 0.
- R2: In the control byte, bit 7 forces channel A, bit 6 forces channel B, bit 3 is the high mode bit and bits 2:0 are the clock select. Bits 7:4 always read as zero. Bits 3:0 read back as written.
- R3: Clock select 001 advances the counter on every clock. Codes 010, 011, 100 and 101 advance it once every 8, 64, 256 and 1024 clocks. Codes 000, 110 and 111 hold it still.
- R4: A compare match happens when the counter has just advanced onto a channel's compare value. One clock after the counter shows that value, the flag is set and the output follows the channel's action: 00 holds, 01 toggles, 10 drives 0, 11 drives 1. A value written into the counter causes no match.
- R5: The mode is {control bit 3, config bits 1:0}. In mode 010 (clear-on-compare), the counter advances from channel A's compare value to 0. In other non-PWM modes it advances to the value plus one and wraps from 255 to 0.
- R6: In a non-PWM mode, a control write with a force bit set changes that channel's output at the next clock edge. The force bit is a strobe: it is not stored and causes no later change.
- R7: A forced change uses the channel's output action as it stands at the moment of the control write.
- R8: A forced change never sets the channel's interrupt flag.
- R9: A forced change never clears or changes the counter, even in clear-on-compare mode when the counter equals compare A.
- R10: In PWM mode (111), force bits have no effect on the outputs, the flags or the counter.
- R11: In PWM mode, action 10 drives the output 1 while the counter is below the compare value and 0 otherwise. Action 11 gives the inverse. Actions 00 and 01 hold the output.
- R12: Writing a one to a flag bit at address 5 clears that flag. A zero leaves it unchanged. A match in the same clock wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write enable |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| wave_a | output | 1 | Channel A waveform output |
| wave_b | output | 1 | Channel B waveform output |
| irq_a | output | 1 | Channel A compare interrupt flag |
| irq_b | output | 1 | Channel B compare interrupt flag |

## Verification
Several rules are checked on every cycle. The upper nibble of the control read is always zero. A rising flag must follow a real match. A force strobe must leave the flag clear. The counter must step by one, wrap at compare A in clear-on-compare mode, or hold when no tick comes. A PWM output with a hold or toggle action must stay stable. Other behaviour can only be shown by the directed scenarios. These include the exact prescaler intervals, the flag and output timing for each of the four actions, and the fact that a force uses the action present when it is written. They also show that a force leaves a clear-on-compare counter in place, the PWM duty levels, and the bit-by-bit clearing of the flags.

// File: rtl/cmpo_pkg.sv
package cmpo_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD   = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_e;

    localparam logic [2:0] A_CFG  = 3'd0;
    localparam logic [2:0] A_CTL  = 3'd1;
    localparam logic [2:0] A_CNT  = 3'd2;
    localparam logic [2:0] A_CMPA = 3'd3;
    localparam logic [2:0] A_CMPB = 3'd4;
    localparam logic [2:0] A_FLG  = 3'd5;

    localparam logic [2:0] MODE_CTC = 3'b010;
    localparam logic [2:0] MODE_PWM = 3'b111;

    localparam int CTL_FRC_A = 7;
    localparam int CTL_FRC_B = 6;
    localparam int CTL_MHI   = 3;

endpackage

// File: rtl/cmpo_prescale.sv
module cmpo_prescale #(
    parameter int PRE_W = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] sel,
    output logic       tick
);
    localparam int TAP1 = 3;
    localparam int TAP2 = 6;
    localparam int TAP3 = 8;
    localparam int TAP4 = PRE_W;

    logic [PRE_W-1:0] pre_d, pre_q;

    always_comb begin
        pre_d = pre_q + 1'b1;
        case (sel)
            3'b001:  tick = 1'b1;
            3'b010:  tick = &pre_q[TAP1-1:0];
            3'b011:  tick = &pre_q[TAP2-1:0];
            3'b100:  tick = &pre_q[TAP3-1:0];
            3'b101:  tick = &pre_q[TAP4-1:0];
            default: tick = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/cmpo_channel.sv
module cmpo_channel
    import cmpo_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] count,
    input  logic         fresh,
    input  logic [W-1:0] cmp,
    input  act_e         act,
    input  logic         force_in,
    input  logic         pwm,
    output logic         match,
    output logic         wave
);
    logic out_d, out_q;
    logic hit;
    logic below;

    always_comb begin
        match = fresh && (count == cmp);
        below = (count < cmp);
        hit   = !pwm && (match || force_in);
        out_d = out_q;
        if (pwm) begin
            case (act)
                ACT_CLEAR: out_d = below;
                ACT_SET:   out_d = !below;
                default:   out_d = out_q;
            endcase
        end else if (hit) begin
            case (act)
                ACT_TOGGLE: out_d = !out_q;
                ACT_CLEAR:  out_d = 1'b0;
                ACT_SET:    out_d = 1'b1;
                default:    out_d = out_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= 1'b0;
        else        out_q <= out_d;
    end

    assign wave = out_q;

endmodule

// File: rtl/cmpo_timer.sv
module cmpo_timer
    import cmpo_pkg::*;
#(
    parameter int W     = 8,
    parameter int PRE_W = 10,
    parameter int NCH   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [2:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       wave_a,
    output logic       wave_b,
    output logic       irq_a,
    output logic       irq_b
);
    localparam int LAST = NCH - 1;

    typedef struct packed {
        logic [1:0]                mode_lo;
        logic                      mode_hi;
        logic [2:0]                clk_sel;
        logic [NCH-1:0][1:0]       act;
        logic [W-1:0]              count;
        logic [NCH-1:0][W-1:0]     cmp;
        logic [NCH-1:0]            flag;
        logic                      fresh;
    } state_t;

    state_t d, q;

    logic           tick;
    logic           pwm;
    logic           ctc;
    logic [NCH-1:0] force_v;
    logic [NCH-1:0] match_v;
    logic [NCH-1:0] wave_v;

    cmpo_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (q.clk_sel),
        .tick  (tick)
    );

    assign pwm = ({q.mode_hi, q.mode_lo} == MODE_PWM);
    assign ctc = ({q.mode_hi, q.mode_lo} == MODE_CTC);

    always_comb begin
        force_v = '0;
        if (wr_en && addr == A_CTL) begin
            force_v[0] = wdata[CTL_FRC_A];
            force_v[1] = wdata[CTL_FRC_B];
        end
    end

    genvar g;
    generate
        for (g = 0; g < NCH; g++) begin : g_ch
            cmpo_channel #(.W(W)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .count    (q.count),
                .fresh    (q.fresh),
                .cmp      (q.cmp[g]),
                .act      (act_e'(q.act[g])),
                .force_in (force_v[g]),
                .pwm      (pwm),
                .match    (match_v[g]),
                .wave     (wave_v[g])
            );
        end
    endgenerate

    always_comb begin
        d = q;
        d.fresh = tick;
        if (tick) begin
            if (ctc && q.count == q.cmp[0]) d.count = '0;
            else                            d.count = q.count + 1'b1;
        end
        if (wr_en) begin
            case (addr)
                A_CFG: begin
                    d.mode_lo = wdata[1:0];
                    d.act[1]  = wdata[3:2];
                    d.act[0]  = wdata[5:4];
                end
                A_CTL: begin
                    d.mode_hi = wdata[CTL_MHI];
                    d.clk_sel = wdata[2:0];
                end
                A_CNT: begin
                    d.count = wdata[W-1:0];
                    d.fresh = 1'b0;
                end
                A_CMPA:  d.cmp[0] = wdata[W-1:0];
                A_CMPB:  d.cmp[1] = wdata[W-1:0];
                A_FLG:   d.flag   = q.flag & ~wdata[NCH-1:0];
                default: ;
            endcase
        end
        d.flag = d.flag | match_v;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CFG:   rdata = {2'b00, q.act[0], q.act[1], q.mode_lo};
            A_CTL:   rdata = {4'b0000, q.mode_hi, q.clk_sel};
            A_CNT:   rdata = q.count;
            A_CMPA:  rdata = q.cmp[0];
            A_CMPB:  rdata = q.cmp[1];
            A_FLG:   rdata = {{(8-NCH){1'b0}}, q.flag};
            default: rdata = '0;
        endcase
    end

    assign wave_a = wave_v[0];
    assign wave_b = wave_v[LAST];
    assign irq_a  = q.flag[0];
    assign irq_b  = q.flag[LAST];

endmodule

// File: rtl/cmpo_timer_chk.sv
module cmpo_timer_chk
    import cmpo_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       wr_en,
    input logic [2:0] addr,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] count,
    input logic [7:0] cmp_a,
    input logic       tick,
    input logic       ctc,
    input logic       pwm,
    input logic [1:0] act_a,
    input logic       wave_a,
    input logic       irq_a,
    input logic       match_a
);
    logic cnt_wr;
    assign cnt_wr = wr_en && (addr == A_CNT);

    assert_ctl_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == A_CTL) |-> (rdata[7:4] == 4'b0000));

    assert_flag_from_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_a) |-> $past(match_a));

    assert_force_no_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == A_CTL && wdata[CTL_FRC_A] && !match_a && !irq_a) |=> !irq_a);

    assert_ctc_wrap_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctc && tick && count == cmp_a && !cnt_wr) |=> (count == 8'd0));

    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !cnt_wr && !(ctc && count == cmp_a)) |=> (count == $past(count) + 8'd1));

    assert_count_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !cnt_wr) |=> $stable(count));

    assert_pwm_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm && !act_a[1] && !wr_en) |=> $stable(wave_a));

endmodule

bind cmpo_timer cmpo_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .count   (q.count),
    .cmp_a   (q.cmp[0]),
    .tick    (tick),
    .ctc     (ctc),
    .pwm     (pwm),
    .act_a   (q.act[0]),
    .wave_a  (wave_a),
    .irq_a   (irq_a),
    .match_a (match_v[0])
);

// File: tb/cmpo_timer_bench.sv
`timescale 1ns/1ps
module cmpo_timer_bench;
    import cmpo_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       wave_a, wave_b, irq_a, irq_b;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cmpo_timer u_cmpo_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .wave_a (wave_a),
        .wave_b (wave_b),
        .irq_a  (irq_a),
        .irq_b  (irq_b)
    );

    task automatic chk(input string req, input int got, input int exp);
        n_vec++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] v);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    function automatic logic [7:0] cfg(input logic [1:0] aa, input logic [1:0] ab,
                                       input logic [1:0] ml);
        return {2'b00, aa, ab, ml};
    endfunction

    task automatic t_reset();
        logic [7:0] v;
        for (int i = 0; i < 6; i++) begin
            peek(3'(i), v);
            chk("R1 reg", v, 0);
        end
        chk("R1 wave_a", wave_a, 0);
        chk("R1 wave_b", wave_b, 0);
        chk("R1 irq_a", irq_a, 0);
        chk("R1 irq_b", irq_b, 0);
    endtask

    task automatic t_ctl_read();
        logic [7:0] v;
        wr(A_CTL, 8'hFF);
        peek(A_CTL, v);
        chk("R2 ctl read", v, 8'h0F);
        wr(A_CTL, 8'h36);
        peek(A_CTL, v);
        chk("R2 ctl read", v, 8'h06);
        wr(A_CTL, 8'h00);
    endtask

    task automatic t_prescale();
        int exp_iv[5] = '{1, 8, 64, 256, 1024};
        logic [2:0] stops[3] = '{3'b000, 3'b110, 3'b111};
        logic [7:0] a, b;
        int n;
        for (int i = 0; i < 5; i++) begin
            wr(A_CTL, 8'h00);
            wr(A_CNT, 8'h00);
            wr(A_CTL, 8'(i + 1));
            peek(A_CNT, a);
            n = 0;
            do begin @(negedge clk); peek(A_CNT, b); n++; end while (b == a && n < 2100);
            a = b; n = 0;
            do begin @(negedge clk); peek(A_CNT, b); n++; end while (b == a && n < 2100);
            chk("R3 interval", n, exp_iv[i]);
            chk("R3 step", b, 8'(a + 1));
        end
        for (int i = 0; i < 3; i++) begin
            wr(A_CTL, 8'h00);
            wr(A_CNT, 8'h33);
            wr(A_CTL, {5'b0, stops[i]});
            repeat (40) @(negedge clk);
            peek(A_CNT, b);
            chk("R3 stopped", b, 8'h33);
        end
        wr(A_CTL, 8'h00);
        wr(A_FLG, 8'h03);
    endtask

    task automatic one_match(input bit chb, input logic [1:0] act, input int exp_w);
        wr(A_CTL, 8'h00);
        wr(A_FLG, 8'h03);
        wr(A_CFG, chb ? cfg(2'b00, act, 2'b00) : cfg(act, 2'b00, 2'b00));
        wr(chb ? A_CMPB : A_CMPA, 8'd20);
        wr(chb ? A_CMPA : A_CMPB, 8'd200);
        wr(A_CNT, 8'd19);
        wr(A_CTL, 8'h01);
        @(negedge clk);
        chk("R4 flag not yet", chb ? irq_b : irq_a, 0);
        @(negedge clk);
        chk("R4 flag set", chb ? irq_b : irq_a, 1);
        chk("R4 action", chb ? wave_b : wave_a, exp_w);
        wr(A_CTL, 8'h00);
    endtask

    task automatic t_match();
        logic [7:0] v;
        one_match(1'b0, 2'b11, 1);
        one_match(1'b0, 2'b10, 0);
        one_match(1'b0, 2'b01, 1);
        one_match(1'b0, 2'b00, 1);
        one_match(1'b1, 2'b11, 1);
        one_match(1'b1, 2'b01, 0);
        wr(A_CTL, 8'h00);
        wr(A_FLG, 8'h03);
        wr(A_CFG, 8'h00);
        wr(A_CNT, 8'd20);
        wr(A_CMPA, 8'd20);
        repeat (3) @(negedge clk);
        chk("R4 write no match", irq_a, 0);
        peek(A_FLG, v);
        chk("R4 flags", v, 0);
    endtask

    task automatic t_flags();
        wr(A_CTL, 8'h00);
        wr(A_CFG, 8'h00);
        wr(A_CMPA, 8'd20);
        wr(A_CMPB, 8'd20);
        wr(A_CNT, 8'd19);
        wr(A_CTL, 8'h01);
        wr(A_CTL, 8'h00);
        @(negedge clk);
        chk("R12 both set a", irq_a, 1);
        chk("R12 both set b", irq_b, 1);
        wr(A_FLG, 8'h01);
        chk("R12 clear a", irq_a, 0);
        chk("R12 keep b", irq_b, 1);
        wr(A_FLG, 8'h00);
        chk("R12 zero keeps b", irq_b, 1);
        wr(A_FLG, 8'h02);
        chk("R12 clear b", irq_b, 0);
    endtask

    task automatic t_ctc(input logic [1:0] ml, input logic [7:0] exp_next, input string tag);
        logic [7:0] v;
        bit seen = 1'b0;
        int got = -1;
        wr(A_CTL, 8'h00);
        wr(A_CFG, cfg(2'b00, 2'b00, ml));
        wr(A_CMPA, 8'd5);
        wr(A_CNT, 8'd0);
        wr(A_CTL, 8'h01);
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            peek(A_CNT, v);
            if (seen && got < 0) got = v;
            if (v == 8'd5) seen = 1'b1;
        end
        wr(A_CTL, 8'h00);
        chk(tag, got, exp_next);
        wr(A_FLG, 8'h03);
    endtask

    task automatic t_force();
        logic [7:0] v;
        wr(A_CTL, 8'h00);
        wr(A_CFG, cfg(2'b11, 2'b00, 2'b00));
        wr(A_FLG, 8'h03);
        wr(A_CMPA, 8'd100);
        wr(A_CMPB, 8'd100);
        wr(A_CNT, 8'd10);
        wr(A_CTL, 8'h80);
        chk("R6 force set A", wave_a, 1);
        peek(A_CTL, v);
        chk("R6 force reads zero", v, 0);
        wr(A_CFG, cfg(2'b10, 2'b00, 2'b00));
        chk("R7 no change before force", wave_a, 1);
        wr(A_CTL, 8'h80);
        chk("R7 force uses clear", wave_a, 0);
        wr(A_CFG, cfg(2'b01, 2'b11, 2'b00));
        wr(A_CTL, 8'h80);
        chk("R7 force uses toggle", wave_a, 1);
        repeat (3) @(negedge clk);
        chk("R6 strobe only once", wave_a, 1);
        wr(A_CTL, 8'h40);
        chk("R6 force B", wave_b, 1);
        chk("R6 A untouched", wave_a, 1);
        peek(A_FLG, v);
        chk("R8 no flags", v, 0);
        peek(A_CNT, v);
        chk("R9 count kept", v, 8'd10);
    endtask

    task automatic t_force_ctc();
        logic [7:0] v;
        wr(A_CTL, 8'h00);
        wr(A_CFG, cfg(2'b01, 2'b00, 2'b10));
        wr(A_FLG, 8'h03);
        wr(A_CMPA, 8'd10);
        wr(A_CNT, 8'd10);
        wr(A_CTL, 8'h80);
        chk("R6 ctc force toggles", wave_a, 0);
        @(negedge clk);
        peek(A_CNT, v);
        chk("R9 ctc count kept", v, 8'd10);
        chk("R8 ctc no flag", irq_a, 0);
    endtask

    task automatic t_pwm();
        logic [7:0] v;
        logic wb;
        wr(A_CTL, 8'h00);
        wr(A_FLG, 8'h03);
        wr(A_CMPA, 8'd100);
        wr(A_CNT, 8'd50);
        wr(A_CFG, cfg(2'b10, 2'b00, 2'b11));
        wr(A_CTL, 8'h08);
        @(negedge clk);
        chk("R11 below high", wave_a, 1);
        wr(A_CNT, 8'd150);
        @(negedge clk);
        chk("R11 above low", wave_a, 0);
        wr(A_CFG, cfg(2'b11, 2'b00, 2'b11));
        @(negedge clk);
        chk("R11 inverse high", wave_a, 1);
        wr(A_CFG, cfg(2'b01, 2'b00, 2'b11));
        @(negedge clk);
        wb = wave_b;
        wr(A_CTL, 8'hC8);
        @(negedge clk);
        chk("R10 A ignored", wave_a, 1);
        chk("R10 B ignored", wave_b, wb);
        peek(A_FLG, v);
        chk("R10 no flags", v, 0);
        peek(A_CNT, v);
        chk("R10 count kept", v, 8'd150);
        wr(A_CTL, 8'h00);
        wr(A_CFG, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_ctl_read();
        t_prescale();
        t_match();
        t_flags();
        t_ctc(2'b10, 8'd0, "R5 ctc wraps at compare A");
        t_ctc(2'b00, 8'd6, "R5 normal passes compare A");
        t_force();
        t_force_ctc();
        t_pwm();
        if (!done) begin
            done = 1'b1;
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_vec++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule